// File: doc/BRIEF.md
# SM4 Iterative Round Engine

This block runs the 32-round SM4 data transform on one 128-bit block at a time, one round per clock. The incoming block is split into four 32-bit words that form a sliding window. Each round mixes three window words with a round key, passes the result through the byte-substitution and linear-diffusion function, and folds it into the oldest word. The round key comes from an external synchronous key memory that the engine addresses itself. Every round's new word is written into a per-round store. A separate result stage takes the final four stored words, reverses their order and presents them as the output block.

The engine is built as either an encryptor or a decryptor through the `DECRYPT` parameter. The two variants differ only in the direction in which round-key addresses are walked. A system places one of each beside the same key memory, each with its own read port, so that both directions run at the same time. A new block is taken only when the key expander reports its keys ready and the engine is idle.

Top module: `sm4_round_engine`

## Requirements
- R1: `in_ready` is high exactly when the engine is idle and `key_ready` is high. A block is taken on a rising clock edge where `in_valid` and `in_ready` are both high. While `key_ready` is low, no block is taken, no key is read and no result appears.
- R2: The accepted block is split with `in_data[127:96]` as word X0, `[95:64]` as X1, `[63:32]` as X2 and `[31:0]` as X3.
- R3: Round i (i = 0..31) produces X(i+4) = X(i) XOR T(X(i+1) XOR X(i+2) XOR X(i+3) XOR rk(i)). T applies the S-box to each byte and then the map L(B) = B ^ (B<<<2) ^ (B<<<10) ^ (B<<<18) ^ (B<<<24). Round indices advance by one each cycle.
- R4: The S-box is S(x) = A(inv(A(x) ^ 0xD3)) ^ 0xD3. Here inv is the multiplicative inverse in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1, with inv(0) = 0. A XORs together, for each set input bit b (bit 0 = LSB), the byte 0xE5 rotated left by b+1.
- R5: The encryptor (`DECRYPT`=0) issues exactly one key read per round, at addresses 0,1,...,31 in that order. The first read is issued in the accept cycle. The key memory returns `rk_data` one clock after the read is sampled.
- R6: The decryptor (`DECRYPT`=1) issues the same reads at addresses 31,30,...,0 in that order, with the datapath otherwise unchanged.
- R7: `out_valid` is high for exactly one cycle, 33 rising edges after the accept edge. At that point `out_data` = {X35, X34, X33, X32}, taken from the per-round store, and it holds that value until the next result.
- R8: From the accept edge until the result is presented, `in_ready` stays low. Any `in_valid` during that time is ignored and leaves the pending result unchanged.
- R9: During and after reset, `out_valid` and `rk_rd_en` are low and `out_data` is zero.
- R10: An encryptor and a decryptor started on the same edge with different blocks each produce their own correct result at the same latency.
- R11: With key and plaintext 0123456789ABCDEFFEDCBA9876543210, the encryptor returns 681EDF34D206965E86B3E94F536E4246. Feeding that value to the decryptor returns the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_ready | input | 1 | Round keys are present in the key memory |
| in_valid | input | 1 | A block is offered on `in_data` |
| in_ready | output | 1 | Engine will take a block this cycle |
| in_data | input | 128 | Block to transform, X0 in the top word |
| out_valid | output | 1 | One-cycle pulse marking a finished block |
| out_data | output | 128 | Transformed block, held between results |
| rk_rd_en | output | 1 | Key memory read request |
| rk_addr | output | 5 | Round-key index to read |
| rk_data | input | 32 | Key word returned one cycle after the read |

## Verification
The bound checker watches the timing skeleton on every cycle. It checks that input is refused while keys are missing or a block is in flight, that the output pulse lands exactly 33 edges after acceptance and lasts one cycle, that round indices step by one, and that key addresses start at the correct end and move by one per read in the parameterised direction. The values themselves — the S-box, the linear map, the word split, the reversed assembly and the known-answer result — can only be shown by the bench's scenarios. The bench compares each output block against an independent software model. It also covers the decryptor round trip, both engines running at once, and stimulus that must be ignored.

// File: rtl/sm4_pkg.sv
package sm4_pkg;

  localparam int unsigned SM4_WORD_W  = 32;
  localparam int unsigned SM4_BLOCK_W = 4 * SM4_WORD_W;

  // field reduction byte for x^8 = x^7+x^6+x^5+x^4+x^2+1
  localparam logic [7:0] GF_REDUCE = 8'hF5;
  // circulant seed and constant of the affine step around the inversion
  localparam logic [7:0] AFF_SEED  = 8'hE5;
  localparam logic [7:0] AFF_CONST = 8'hD3;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_EMIT = 2'd2
  } eng_state_e;

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} << n;
    return d[15:8];
  endfunction

  function automatic logic [31:0] rotl32(input logic [31:0] v, input int n);
    logic [63:0] d;
    d = {v, v} << n;
    return d[63:32];
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= sh;
      sh = sh[7] ? ((sh << 1) ^ GF_REDUCE) : (sh << 1);
    end
    return acc;
  endfunction

  // a^254 equals the inverse for a != 0 and gives 0 for a == 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] x);
    logic [7:0] y;
    y = '0;
    for (int b = 0; b < 8; b++) begin
      if (x[b]) y ^= rotl8(AFF_SEED, b + 1);
    end
    return y;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    return affine(gf_inv(affine(x) ^ AFF_CONST)) ^ AFF_CONST;
  endfunction

  function automatic logic [31:0] tau(input logic [31:0] w);
    logic [31:0] o;
    for (int i = 0; i < 4; i++) o[i*8 +: 8] = sbox(w[i*8 +: 8]);
    return o;
  endfunction

  function automatic logic [31:0] lin_mix(input logic [31:0] b);
    return b ^ rotl32(b, 2) ^ rotl32(b, 10) ^ rotl32(b, 18) ^ rotl32(b, 24);
  endfunction

  function automatic logic [31:0] t_round(input logic [31:0] w);
    return lin_mix(tau(w));
  endfunction

endpackage

// File: rtl/sm4_round_ctrl.sv
module sm4_round_ctrl
  import sm4_pkg::*;
#(
  parameter int ROUNDS  = 32,
  parameter bit DECRYPT = 1'b0,
  localparam int CNT_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             key_ready,
  output logic             in_ready,
  output logic             accept,
  output logic             round_en,
  output logic [CNT_W-1:0] round_idx,
  output logic             emit,
  output logic             rk_rd_en,
  output logic [CNT_W-1:0] rk_addr
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROUNDS - 1);

  eng_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_round;
  logic [CNT_W-1:0] fetch_idx;

  assign last_round = (cnt_q == LAST_IDX);
  assign in_ready   = (state_q == ENG_IDLE) && key_ready;
  assign accept     = in_valid && in_ready;
  assign round_en   = (state_q == ENG_RUN);
  assign round_idx  = cnt_q;
  assign emit       = (state_q == ENG_EMIT);

  // key for round n+1 is requested while round n computes
  assign fetch_idx  = round_en ? (cnt_q + CNT_W'(1)) : '0;
  assign rk_rd_en   = accept || (round_en && !last_round);

  generate
    if (DECRYPT) begin : g_desc
      assign rk_addr = LAST_IDX - fetch_idx;
    end else begin : g_asc
      assign rk_addr = fetch_idx;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          cnt_q <= '0;
          if (accept) state_q <= ENG_RUN;
        end
        ENG_RUN: begin
          if (last_round) begin
            state_q <= ENG_EMIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ENG_EMIT: state_q <= ENG_IDLE;
        default:  state_q <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sm4_round_dp.sv
module sm4_round_dp
  import sm4_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [SM4_BLOCK_W-1:0] in_block,
  input  logic                   step,
  input  logic [SM4_WORD_W-1:0]  rk_word,
  output logic [SM4_WORD_W-1:0]  new_word
);

  localparam int W = SM4_WORD_W;

  // win_q[0] is the oldest word X(i), win_q[3] the newest X(i+3)
  logic [3:0][W-1:0] win_q;
  logic [W-1:0]      mix;

  always_comb begin
    mix      = win_q[1] ^ win_q[2] ^ win_q[3] ^ rk_word;
    new_word = win_q[0] ^ t_round(mix);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (load) begin
      for (int k = 0; k < 4; k++) win_q[k] <= in_block[(4-k)*W-1 -: W];
    end else if (step) begin
      win_q[0] <= win_q[1];
      win_q[1] <= win_q[2];
      win_q[2] <= win_q[3];
      win_q[3] <= new_word;
    end
  end

endmodule

// File: rtl/sm4_round_store.sv
module sm4_round_store
  import sm4_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int W     = SM4_WORD_W,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_idx,
  input  logic [W-1:0]      wr_data,
  output logic [3:0][W-1:0] tail_w
);

  logic [W-1:0] mem_q [ROUNDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  // tail_w[0] is the word of round ROUNDS-4, tail_w[3] the final round
  for (genvar k = 0; k < 4; k++) begin : g_tail
    assign tail_w[k] = mem_q[ROUNDS-4+k];
  end

endmodule

// File: rtl/sm4_result_stage.sv
module sm4_result_stage
  import sm4_pkg::*;
#(
  localparam int W = SM4_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [3:0][W-1:0] tail_w,
  output logic              out_valid,
  output logic [4*W-1:0]    out_block
);

  logic [4*W-1:0] reversed;

  // newest word goes to the top of the block
  for (genvar k = 0; k < 4; k++) begin : g_rev
    assign reversed[(k+1)*W-1 -: W] = tail_w[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_block <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_block <= reversed;
    end
  end

endmodule

// File: rtl/sm4_round_engine.sv
module sm4_round_engine
  import sm4_pkg::*;
#(
  parameter int ROUNDS  = 32,
  parameter bit DECRYPT = 1'b0,
  localparam int CNT_W  = $clog2(ROUNDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   key_ready,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SM4_BLOCK_W-1:0] in_data,
  output logic                   out_valid,
  output logic [SM4_BLOCK_W-1:0] out_data,
  output logic                   rk_rd_en,
  output logic [CNT_W-1:0]       rk_addr,
  input  logic [SM4_WORD_W-1:0]  rk_data
);

  // internal events, named for the bound checker
  logic                         accept;
  logic                         round_en;
  logic [CNT_W-1:0]             round_idx;
  logic                         emit;
  logic [SM4_WORD_W-1:0]        round_word;
  logic [3:0][SM4_WORD_W-1:0]   tail_w;

  sm4_round_ctrl #(
    .ROUNDS  (ROUNDS),
    .DECRYPT (DECRYPT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .key_ready (key_ready),
    .in_ready  (in_ready),
    .accept    (accept),
    .round_en  (round_en),
    .round_idx (round_idx),
    .emit      (emit),
    .rk_rd_en  (rk_rd_en),
    .rk_addr   (rk_addr)
  );

  sm4_round_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .in_block (in_data),
    .step     (round_en),
    .rk_word  (rk_data),
    .new_word (round_word)
  );

  sm4_round_store #(
    .ROUNDS (ROUNDS)
  ) u_store (
    .clk     (clk),
    .wr_en   (round_en),
    .wr_idx  (round_idx),
    .wr_data (round_word),
    .tail_w  (tail_w)
  );

  sm4_result_stage u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (emit),
    .tail_w    (tail_w),
    .out_valid (out_valid),
    .out_block (out_data)
  );

endmodule

// File: rtl/sm4_round_engine_chk.sv
module sm4_round_engine_chk #(
  parameter int ROUNDS  = 32,
  parameter bit DECRYPT = 1'b0,
  localparam int CNT_W  = $clog2(ROUNDS),
  localparam int LAT_W  = $clog2(ROUNDS + 3)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_ready,
  input logic             in_ready,
  input logic             accept,
  input logic             round_en,
  input logic [CNT_W-1:0] round_idx,
  input logic             rk_rd_en,
  input logic [CNT_W-1:0] rk_addr,
  input logic             out_valid
);

  localparam logic [LAT_W-1:0] LAT_DUE    = LAT_W'(ROUNDS + 2);
  localparam logic [CNT_W-1:0] FIRST_ADDR = DECRYPT ? CNT_W'(ROUNDS - 1) : '0;

  // 1 in the cycle after acceptance, LAT_DUE in the result cycle
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_q <= '0;
    else if (accept)           lat_q <= LAT_W'(1);
    else if (lat_q == LAT_DUE) lat_q <= '0;
    else if (lat_q != '0)      lat_q <= lat_q + LAT_W'(1);
  end

  p_ready_needs_keys_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> key_ready);

  p_busy_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q != '0 && lat_q != LAT_DUE) |-> !in_ready);

  p_result_on_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_q == LAT_DUE));

  p_result_not_missed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q == LAT_DUE) |-> out_valid);

  p_result_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_round_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (round_en && $past(round_en)) |-> (round_idx == $past(round_idx) + CNT_W'(1)));

  p_first_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (rk_rd_en && rk_addr == FIRST_ADDR));

  generate
    if (DECRYPT) begin : g_desc
      p_key_desc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_rd_en && $past(rk_rd_en)) |-> (rk_addr == $past(rk_addr) - CNT_W'(1)));
    end else begin : g_asc
      p_key_asc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_rd_en && $past(rk_rd_en)) |-> (rk_addr == $past(rk_addr) + CNT_W'(1)));
    end
  endgenerate

endmodule

bind sm4_round_engine sm4_round_engine_chk #(
  .ROUNDS  (ROUNDS),
  .DECRYPT (DECRYPT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_ready (key_ready),
  .in_ready  (in_ready),
  .accept    (accept),
  .round_en  (round_en),
  .round_idx (round_idx),
  .rk_rd_en  (rk_rd_en),
  .rk_addr   (rk_addr),
  .out_valid (out_valid)
);

// File: tb/sm4_round_engine_bench.sv
module sm4_round_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 4;
  localparam int LOG_DEPTH  = 512;
  localparam logic [127:0] KAT_KEY = 128'h0123456789ABCDEFFEDCBA9876543210;
  localparam logic [127:0] KAT_CT  = 128'h681EDF34D206965E86B3E94F536E4246;
  localparam logic [127:0] VEC [NVEC] = '{
    128'h0123456789ABCDEFFEDCBA9876543210,
    128'h00000000000000000000000000000000,
    128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF,
    128'hA5A5A5A55A5A5A5A0F0F0F0FF0F0F0F0
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_ready = 1'b0;
  logic         e_in_valid = 1'b0, d_in_valid = 1'b0;
  logic [127:0] e_in_data = '0, d_in_data = '0;
  logic         e_in_ready, d_in_ready, e_out_valid, d_out_valid;
  logic [127:0] e_out_data, d_out_data;
  logic         e_rk_rd_en, d_rk_rd_en;
  logic [4:0]   e_rk_addr, d_rk_addr;
  logic [31:0]  e_rk_data = '0, d_rk_data = '0;

  logic [7:0]   sb_tab [256];
  logic [31:0]  rk_mem [32];
  logic [4:0]   e_log [LOG_DEPTH];
  logic [4:0]   d_log [LOG_DEPTH];
  int           e_log_n = 0, d_log_n = 0;
  int           total = 0, bad = 0;
  bit           wd_hit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm4_round_engine #(.ROUNDS(32), .DECRYPT(1'b0)) u_sm4_round_engine (
    .clk(clk), .rst_n(rst_n), .key_ready(key_ready),
    .in_valid(e_in_valid), .in_ready(e_in_ready), .in_data(e_in_data),
    .out_valid(e_out_valid), .out_data(e_out_data),
    .rk_rd_en(e_rk_rd_en), .rk_addr(e_rk_addr), .rk_data(e_rk_data));

  sm4_round_engine #(.ROUNDS(32), .DECRYPT(1'b1)) u_sm4_round_engine_dec (
    .clk(clk), .rst_n(rst_n), .key_ready(key_ready),
    .in_valid(d_in_valid), .in_ready(d_in_ready), .in_data(d_in_data),
    .out_valid(d_out_valid), .out_data(d_out_data),
    .rk_rd_en(d_rk_rd_en), .rk_addr(d_rk_addr), .rk_data(d_rk_data));

  // key memory: one read port per engine, data one edge after the request
  always @(posedge clk) begin
    if (e_rk_rd_en) begin
      e_rk_data <= rk_mem[e_rk_addr];
      if (e_log_n < LOG_DEPTH) e_log[e_log_n] <= e_rk_addr;
      e_log_n <= e_log_n + 1;
    end
    if (d_rk_rd_en) begin
      d_rk_data <= rk_mem[d_rk_addr];
      if (d_log_n < LOG_DEPTH) d_log[d_log_n] <= d_rk_addr;
      d_log_n <= d_log_n + 1;
    end
  end

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p ^= (15'(9'h1F5) << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_aff(input logic [7:0] x);
    logic [7:0]  y;
    logic [15:0] t;
    y = '0;
    for (int b = 0; b < 8; b++) begin
      t = {8'hE5, 8'hE5} >> (7 - b);
      if (x[b]) y ^= t[7:0];
    end
    return y;
  endfunction

  function automatic logic [31:0] m_rol(input logic [31:0] v, input int n);
    logic [63:0] t;
    t = {v, v} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] m_sub(input logic [31:0] w);
    return {sb_tab[w[31:24]], sb_tab[w[23:16]], sb_tab[w[15:8]], sb_tab[w[7:0]]};
  endfunction

  function automatic logic [31:0] m_t(input logic [31:0] w);
    logic [31:0] b;
    b = m_sub(w);
    return b ^ m_rol(b, 2) ^ m_rol(b, 10) ^ m_rol(b, 18) ^ m_rol(b, 24);
  endfunction

  function automatic logic [31:0] m_tk(input logic [31:0] w);
    logic [31:0] b;
    b = m_sub(w);
    return b ^ m_rol(b, 13) ^ m_rol(b, 23);
  endfunction

  function automatic logic [127:0] m_enc(input logic [127:0] blk);
    logic [31:0] x [36];
    for (int k = 0; k < 4; k++) x[k] = blk[127 - 32*k -: 32];
    for (int i = 0; i < 32; i++)
      x[i+4] = x[i] ^ m_t(x[i+1] ^ x[i+2] ^ x[i+3] ^ rk_mem[i]);
    return {x[35], x[34], x[33], x[32]};
  endfunction

  task automatic build_model(input logic [127:0] key);
    logic [31:0] fk [4];
    logic [31:0] kk [36];
    logic [31:0] ck;
    logic [7:0]  a, inv;
    for (int v = 0; v < 256; v++) begin
      a = m_aff(8'(v)) ^ 8'hD3;
      inv = 8'h00;
      for (int c = 1; c < 256; c++) if (m_mul(a, 8'(c)) == 8'h01) inv = 8'(c);
      sb_tab[v] = m_aff(inv) ^ 8'hD3;
    end
    fk[0] = 32'hA3B1BAC6; fk[1] = 32'h56AA3350;
    fk[2] = 32'h677D9197; fk[3] = 32'hB27022DC;
    for (int k = 0; k < 4; k++) kk[k] = key[127 - 32*k -: 32] ^ fk[k];
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 4; j++) ck[31 - 8*j -: 8] = 8'(((4*i + j) * 7) % 256);
      kk[i+4] = kk[i] ^ m_tk(kk[i+1] ^ kk[i+2] ^ kk[i+3] ^ ck);
      rk_mem[i] = kk[i+4];
    end
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // start one or both engines on the same edge and collect results
  task automatic run_pair(input bit use_e, input logic [127:0] pe,
                          input bit use_d, input logic [127:0] pd,
                          output logic [127:0] re, output logic [127:0] rdv,
                          output int le, output int ld);
    bit got_e, got_d;
    got_e = !use_e; got_d = !use_d;
    re = '0; rdv = '0; le = -1; ld = -1;
    @(negedge clk);
    e_in_valid = use_e; e_in_data = pe;
    d_in_valid = use_d; d_in_data = pd;
    @(posedge clk);
    @(negedge clk);
    e_in_valid = 1'b0; d_in_valid = 1'b0;
    for (int n = 1; n <= 60 && !(got_e && got_d); n++) begin
      @(posedge clk);
      @(negedge clk);
      if (!got_e && e_out_valid) begin got_e = 1'b1; le = n; re = e_out_data; end
      if (!got_d && d_out_valid) begin got_d = 1'b1; ld = n; rdv = d_out_data; end
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic run_tests();
    logic [127:0] re, rdv, ct_model [NVEC];
    int le, ld, e_start, d_start, hits, lat;
    bit ready_seen;
    logic [127:0] busy_res;

    build_model(KAT_KEY);
    for (int i = 0; i < NVEC; i++) ct_model[i] = m_enc(VEC[i]);

    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "out_valid in reset", 128'(e_out_valid), 128'd0);
    chk("R9", "rk_rd_en in reset", 128'(e_rk_rd_en | d_rk_rd_en), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "out_data after reset", e_out_data, 128'd0);
    chk("R1", "in_ready without keys", 128'(e_in_ready | d_in_ready), 128'd0);
    key_ready = 1'b1;
    #1;
    chk("R1", "in_ready with keys", 128'({e_in_ready, d_in_ready}), 128'd3);

    // R11, R2, R3, R4, R5: known answer through the encryptor
    e_start = e_log_n;
    run_pair(1'b1, KAT_KEY, 1'b0, '0, re, rdv, le, ld);
    chk("R11", "encrypt known answer", re, KAT_CT);
    chk("R7", "encrypt latency", 128'(le), 128'd33);
    chk("R5", "encrypt key read count", 128'(e_log_n - e_start), 128'd32);
    for (int k = 0; k < 32; k++)
      if (e_log[e_start + k] != 5'(k))
        chk("R5", "ascending key address", 128'(e_log[e_start + k]), 128'(k));

    // R11, R6: decryptor round trip
    d_start = d_log_n;
    run_pair(1'b0, '0, 1'b1, KAT_CT, re, rdv, le, ld);
    chk("R11", "decrypt returns plaintext", rdv, KAT_KEY);
    chk("R7", "decrypt latency", 128'(ld), 128'd33);
    chk("R6", "decrypt key read count", 128'(d_log_n - d_start), 128'd32);
    for (int k = 0; k < 32; k++)
      if (d_log[d_start + k] != 5'(31 - k))
        chk("R6", "descending key address", 128'(d_log[d_start + k]), 128'(31 - k));

    // R10, R2, R3, R4: table walk with both engines started together
    for (int i = 0; i < NVEC; i++) begin
      run_pair(1'b1, VEC[i], 1'b1, ct_model[(i + 1) % NVEC], re, rdv, le, ld);
      chk("R3", $sformatf("encrypt vector %0d", i), re, ct_model[i]);
      chk("R10", $sformatf("concurrent decrypt vector %0d", i), rdv, VEC[(i + 1) % NVEC]);
      chk("R10", $sformatf("equal latency vector %0d", i), 128'(ld), 128'(le));
    end

    // R8: offers while busy are refused and do not disturb the result
    hits = 0; lat = -1; ready_seen = 1'b0; busy_res = '0;
    @(negedge clk);
    e_in_valid = 1'b1; e_in_data = VEC[3];
    @(posedge clk);
    @(negedge clk);
    e_in_valid = 1'b0;
    for (int n = 1; n <= 70; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (e_out_valid) begin
        hits++;
        if (hits == 1) begin lat = n; busy_res = e_out_data; end
      end
      if (n >= 5 && n <= 20 && e_in_ready) ready_seen = 1'b1;
      e_in_valid = (n >= 4 && n < 20);
      e_in_data  = VEC[0];
    end
    e_in_valid = 1'b0;
    chk("R8", "in_ready while busy", 128'(ready_seen), 128'd0);
    chk("R8", "result after ignored offers", busy_res, ct_model[3]);
    chk("R8", "results produced", 128'(hits), 128'd1);
    chk("R7", "latency with busy offers", 128'(lat), 128'd33);

    // R1: no acceptance while keys are missing
    key_ready = 1'b0;
    e_start = e_log_n;
    hits = 0; ready_seen = 1'b0;
    @(negedge clk);
    e_in_valid = 1'b1; e_in_data = VEC[1];
    for (int n = 0; n < 40; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (e_out_valid) hits++;
      if (e_in_ready) ready_seen = 1'b1;
    end
    e_in_valid = 1'b0;
    chk("R1", "in_ready without keys", 128'(ready_seen), 128'd0);
    chk("R1", "outputs without keys", 128'(hits), 128'd0);
    chk("R1", "key reads without keys", 128'(e_log_n - e_start), 128'd0);
    chk("R7", "output held after pulse", e_out_data, ct_model[3]);
  endtask

  initial begin
    fork
      run_tests();
      begin
        #(CLK_PERIOD * 150000);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule